// File: doc/BRIEF.md
# Horizontal Resampler Step Generator

This block produces source sample positions for a horizontal resampler. Software hands it one packed word with a source width and a destination width, plus a pre-divide choice. The block works out a fixed-point step in which unity scale is 2^21. It computes that step once, with a bit-serial divider, and holds it.

A start-of-line strobe then zeroes a position accumulator. Each per-output-pixel enable produces one registered result: the integer source index and a 4-bit phase that a filter uses to choose its coefficient set. The accumulator then moves forward by one step.

For enlargement, software passes the full source width. For reduction, it selects a halving or quartering pre-divide, and the block applies that to the source width before the division. A destination width of zero raises an error and keeps the output silent, so no division by zero is attempted.

Top module: `hscale_stepgen`

## Requirements
- R1: Once `step_ready` is high, `step_master` equals ceil(eff_src * 2^21 / dst). The result is rounded up whenever the division leaves a remainder.
- R2: The pre-divide code on `div_sel` sets eff_src:
  - 2'b00: eff_src = src.
  - 2'b01: eff_src = src >> 1.
  - 2'b10 and 2'b11: eff_src = src >> 2.
- R3: On a `cfg_load` pulse, the block latches the source width from `cfg_widths[15:0]`, the destination width from `cfg_widths[31:16]`, and `div_sel`.
- R4: `step_plane` equals `step_master` >> 2, and `step_aux` equals `step_master` >> 1.
- R5: A load with a destination width of 0 sets `cfg_err` high and keeps `step_ready` low. While that holds, `pix_en` never produces `out_valid`. The next load with a nonzero destination width clears `cfg_err`.
- R6: `step_ready` is low in the cycle after `cfg_load` and stays low until the new step is available. `pix_en` is ignored while `step_ready` is low.
- R7: `line_start` zeroes the position accumulator. A pixel enabled together with `line_start`, or as the first pixel after a line start, reports index 0 and phase 0.
- R8: Each `pix_en` cycle with `step_ready` high gives `out_valid` high in the next cycle. In that cycle, `src_idx` holds accumulator bits [36:21] and `phase` holds accumulator bits [20:17], both from the accumulator value before the advance. The accumulator then grows by `step_master`. A cycle without `pix_en` gives `out_valid` low in the next cycle.
- R9: After reset, `step_ready`, `cfg_err` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Latch widths and pre-divide, start step computation |
| cfg_widths | input | 32 | Source width in the low half, destination width in the high half |
| div_sel | input | 2 | Pre-divide code: 00 none, 01 halve, 1x quarter |
| line_start | input | 1 | Start of output line, zeroes the accumulator |
| pix_en | input | 1 | Produce one output pixel position |
| step_ready | output | 1 | Step value valid |
| cfg_err | output | 1 | Last load had a zero destination width |
| step_master | output | 37 | Master step, unity = 2^21 |
| step_plane | output | 37 | Per-plane step (master >> 2) |
| step_aux | output | 37 | Auxiliary value (master >> 1) |
| out_valid | output | 1 | Index and phase valid |
| src_idx | output | 16 | Integer source sample index |
| phase | output | 4 | Fraction phase for coefficient selection |

## Verification
The hardest cases to reach are in the rounding of the step. A remainder appears only for some width pairs, and the extreme pair of source 0xFFFF and destination 1 drives the quotient to its full 37-bit width. The bench therefore picks widths whose exact products leave known remainders, and it also uses that extreme pair. It then walks a line of pixels with idle gaps, and compares each index and phase against multiples of the step that the bench computes itself. Pixel enables issued during the divide and after a zero-width load check that the outputs stay silent in those two states.

// File: rtl/hscale_pkg.sv
package hscale_pkg;

  typedef enum logic [1:0] {
    PD_NONE    = 2'b00,
    PD_HALF    = 2'b01,
    PD_QUARTER = 2'b10
  } predivide_e;

  function automatic logic [15:0] apply_predivide(input logic [15:0] w,
                                                  input logic [1:0]  sel);
    logic [15:0] r;
    case (sel)
      PD_NONE: r = w;
      PD_HALF: r = w >> 1;
      default: r = w >> 2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hscale_divider.sv
// Restoring divider, one quotient bit per cycle, result rounded up.
module hscale_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quot_ceil
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [NUM_W-1:0] num_sh;
  logic [NUM_W-1:0] quot;
  logic [DEN_W-1:0] den_r;
  logic [DEN_W-1:0] rem;
  logic             fin;
  logic [DEN_W:0]   rem_sh;
  logic             take;

  always_comb begin
    rem_sh = {rem, num_sh[NUM_W-1]};
    take   = (rem_sh >= {1'b0, den_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      fin       <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      num_sh    <= '0;
      quot      <= '0;
      den_r     <= '0;
      rem       <= '0;
      quot_ceil <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        fin    <= 1'b0;
        cnt    <= CNT_W'(NUM_W);
        num_sh <= num;
        den_r  <= den;
        rem    <= '0;
        quot   <= '0;
      end else if (busy) begin
        num_sh <= num_sh << 1;
        quot   <= {quot[NUM_W-2:0], take};
        rem    <= take ? DEN_W'(rem_sh - {1'b0, den_r}) : rem_sh[DEN_W-1:0];
        cnt    <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end else if (fin) begin
        fin       <= 1'b0;
        done      <= 1'b1;
        quot_ceil <= quot + NUM_W'(rem != '0);
      end
    end
  end

  // R1: the partial remainder never reaches the divisor during the iterations
  p_rem_below_den_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < den_r));

  // R1: completion pulse only after the iteration phase
  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: rtl/hscale_accum.sv
// Per-line position accumulator with registered index and phase.
module hscale_accum #(
  parameter int STEP_W = 37,
  parameter int FRAC_W = 21,
  parameter int IDX_W  = 16,
  parameter int PH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              line_start,
  input  logic              pix_en,
  output logic              out_valid,
  output logic [IDX_W-1:0]  src_idx,
  output logic [PH_W-1:0]   phase
);
  localparam int ACC_W = FRAC_W + IDX_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_cur;

  always_comb acc_cur = line_start ? '0 : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_valid <= 1'b0;
      src_idx   <= '0;
      phase     <= '0;
    end else if (!ready_i) begin
      acc       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= pix_en;
      if (pix_en) begin
        src_idx <= acc_cur[FRAC_W +: IDX_W];
        phase   <= acc_cur[FRAC_W-1 -: PH_W];
        acc     <= acc_cur + ACC_W'(step_i);
      end else begin
        acc     <= acc_cur;
      end
    end
  end

  // R6: no output position without a valid step in the cycle before
  p_valid_needs_ready_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(ready_i));

  // R7: a pixel issued with the line strobe lands on sample 0, phase 0
  p_first_pixel_r7: assert property (@(posedge clk) disable iff (rst)
    (ready_i && line_start && pix_en) |=> (src_idx == '0 && phase == '0));

  // R8: an idle cycle yields no output
  p_idle_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> !out_valid);

endmodule

// File: rtl/hscale_stepgen.sv
module hscale_stepgen #(
  parameter int WID_W  = 16,
  parameter int FRAC_W = 21,
  parameter int PH_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_load,
  input  logic [2*WID_W-1:0]        cfg_widths,
  input  logic [1:0]                div_sel,
  input  logic                      line_start,
  input  logic                      pix_en,
  output logic                      step_ready,
  output logic                      cfg_err,
  output logic [WID_W+FRAC_W-1:0]   step_master,
  output logic [WID_W+FRAC_W-1:0]   step_plane,
  output logic [WID_W+FRAC_W-1:0]   step_aux,
  output logic                      out_valid,
  output logic [WID_W-1:0]          src_idx,
  output logic [PH_W-1:0]           phase
);
  import hscale_pkg::*;

  localparam int STEP_W = WID_W + FRAC_W;

  logic [WID_W-1:0]  src_w;
  logic [WID_W-1:0]  dst_w;
  logic [WID_W-1:0]  eff_src;
  logic              div_start;
  logic [STEP_W-1:0] div_num;
  logic              div_busy;
  logic              div_done;
  logic [STEP_W-1:0] div_q;

  always_comb begin
    src_w     = cfg_widths[WID_W-1:0];
    dst_w     = cfg_widths[2*WID_W-1:WID_W];
    eff_src   = apply_predivide(src_w, div_sel);
    div_num   = {eff_src, {FRAC_W{1'b0}}};
    div_start = cfg_load && (dst_w != '0);
  end

  hscale_divider #(.NUM_W(STEP_W), .DEN_W(WID_W)) div_i (
    .clk       (clk),
    .rst       (rst),
    .start     (div_start),
    .num       (div_num),
    .den       (dst_w),
    .busy      (div_busy),
    .done      (div_done),
    .quot_ceil (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_ready  <= 1'b0;
      cfg_err     <= 1'b0;
      step_master <= '0;
      step_plane  <= '0;
      step_aux    <= '0;
    end else if (cfg_load) begin
      step_ready <= 1'b0;
      cfg_err    <= (dst_w == '0);
    end else if (div_done && !cfg_err) begin
      step_ready  <= 1'b1;
      step_master <= div_q;
      step_plane  <= div_q >> 2;
      step_aux    <= div_q >> 1;
    end
  end

  hscale_accum #(.STEP_W(STEP_W), .FRAC_W(FRAC_W), .IDX_W(WID_W), .PH_W(PH_W)) acc_i (
    .clk        (clk),
    .rst        (rst),
    .ready_i    (step_ready),
    .step_i     (step_master),
    .line_start (line_start),
    .pix_en     (pix_en),
    .out_valid  (out_valid),
    .src_idx    (src_idx),
    .phase      (phase)
  );

  // R5: an error load never leaves a usable step
  p_err_blocks_ready_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !step_ready);

  // R6: a load always withdraws the previous step
  p_load_drops_ready_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !step_ready);

  // R1: a published step holds until the next load
  p_step_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (step_ready && $past(step_ready)) |-> $stable(step_master));

  // R4: derived values are never wider than their shift allows
  p_plane_top_clear_r4: assert property (@(posedge clk) disable iff (rst)
    step_ready |-> (step_plane[STEP_W-1 -: 2] == 2'b00 && step_aux[STEP_W-1] == 1'b0));

endmodule

// File: tb/hscale_stepgen_tb.sv
module hscale_stepgen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_load;
  logic [31:0] cfg_widths;
  logic [1:0]  div_sel;
  logic        line_start;
  logic        pix_en;
  logic        step_ready;
  logic        cfg_err;
  logic [36:0] step_master;
  logic [36:0] step_plane;
  logic [36:0] step_aux;
  logic        out_valid;
  logic [15:0] src_idx;
  logic [3:0]  phase;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hscale_stepgen dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_widths(cfg_widths),
    .div_sel(div_sel), .line_start(line_start), .pix_en(pix_en),
    .step_ready(step_ready), .cfg_err(cfg_err), .step_master(step_master),
    .step_plane(step_plane), .step_aux(step_aux), .out_valid(out_valid),
    .src_idx(src_idx), .phase(phase)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_step(input int src, input int dst, input int sel);
    logic [63:0] eff, num, q;
    eff = (sel == 0) ? 64'(src) : (sel == 1) ? 64'(src >> 1) : 64'(src >> 2);
    num = eff << 21;
    q   = num / 64'(dst);
    if (q * 64'(dst) != num) q = q + 1;
    return q;
  endfunction

  // R3 R6: load, confirm ready drops, pixels ignored, wait for the result
  task automatic load_cfg(input int src, input int dst, input int sel);
    @(negedge clk);
    cfg_widths = {16'(dst), 16'(src)};
    div_sel    = 2'(sel);
    cfg_load   = 1'b1;
    @(negedge clk);
    cfg_load   = 1'b0;
    check("R6 ready low after load", 64'(step_ready), 64'd0);
    pix_en = 1'b1;
    @(negedge clk);
    pix_en = 1'b0;
    check("R6 pix_en ignored while busy", 64'(out_valid), 64'd0);
    for (int i = 0; i < 100 && !step_ready; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R9 ready after reset", 64'(step_ready), 64'd0);
    check("R9 err after reset", 64'(cfg_err), 64'd0);
    check("R9 valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_step(input string tag, input int src, input int dst, input int sel);
    logic [63:0] e;
    e = ref_step(src, dst, sel);
    load_cfg(src, dst, sel);
    check({tag, " ready"}, 64'(step_ready), 64'd1);
    check({tag, " step"}, 64'(step_master), e);
    check("R4 plane step", 64'(step_plane), e >> 2);
    check("R4 aux step", 64'(step_aux), e >> 1);
  endtask

  task automatic t_zero_dst;
    load_cfg(100, 0, 0);
    check("R5 err set", 64'(cfg_err), 64'd1);
    check("R5 ready low", 64'(step_ready), 64'd0);
    @(negedge clk);
    line_start = 1'b1; pix_en = 1'b1;
    @(negedge clk);
    line_start = 1'b0; pix_en = 1'b0;
    check("R5 no output", 64'(out_valid), 64'd0);
    load_cfg(64, 32, 0);
    check("R5 err cleared", 64'(cfg_err), 64'd0);
    check("R5 step after recovery", 64'(step_master), ref_step(64, 32, 0));
  endtask

  // R7 R8: a line with idle gaps, then a second line restart
  task automatic t_line(input int n);
    logic [63:0] st, acc;
    st  = ref_step(720, 500, 1);
    load_cfg(720, 500, 1);
    for (int ln = 0; ln < 2; ln++) begin
      acc = 0;
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        line_start = (k == 0);
        pix_en     = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        pix_en     = 1'b0;
        check("R8 valid", 64'(out_valid), 64'd1);
        check(k == 0 ? "R7 first index" : "R8 index", 64'(src_idx), (acc >> 21) & 64'hFFFF);
        check(k == 0 ? "R7 first phase" : "R8 phase", 64'(phase), (acc >> 17) & 64'hF);
        acc = acc + st;
        if (k % 3 == 1) begin
          @(negedge clk);
          check("R8 idle no valid", 64'(out_valid), 64'd0);
        end
      end
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_load = 1'b0; cfg_widths = '0; div_sel = '0;
    line_start = 1'b0; pix_en = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_step("R1 enlarge exact", 100, 400, 0);
    t_step("R1 round up", 3, 7, 0);
    t_step("R2 halve", 720, 500, 1);
    t_step("R2 quarter", 720, 200, 2);
    t_step("R2 code3 quarter", 720, 200, 3);
    t_step("R1 extreme", 16'hFFFF, 1, 0);
    t_zero_dst();
    t_line(12);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule